// File: doc/BRIEF.md
# Word/Byte ALU with Condition Codes

This block is the combinational arithmetic and logic stage of a 16-bit processor datapath. It receives an operation that has already been decoded, a byte-width flag, a source operand, a destination operand and the current four condition flags. From these it produces a result word, a write-back enable and the next values of the negative (N), zero (Z), overflow (V) and carry (C) flags. Operand fetch and addressing happen elsewhere. Multiply, divide and floating point are not part of this block.

Two groups of operations are supported. The first group takes two operands: move, compare, bit test, bit clear, bit set, add and subtract. The second group takes one operand, the destination: clear, complement, increment, decrement, negate, add carry, subtract carry, test, the two rotates through carry, the two arithmetic shifts, byte swap and sign extend.

In byte mode, the operation acts on the low byte. The upper byte of the result is then a copy of the destination's upper byte, so a caller can write the whole word back without disturbing the upper byte. Compare, bit test and test only update the flags; they do not request a write-back.

Top module: `wb_alu`

## Requirements
- R1: `op_i` has the following encoding: 0 move, 1 compare, 2 bit test, 3 bit clear, 4 bit set, 5 add, 6 subtract, 7 clear, 8 complement, 9 increment, 10 decrement, 11 negate, 12 add carry, 13 subtract carry, 14 test, 15 rotate right, 16 rotate left, 17 arithmetic shift right, 18 arithmetic shift left, 19 swap bytes, 20 sign extend. `wr_en_o` is 0 for compare, bit test and test, and 1 for every other code from 0 to 20. The value of `res_o` has no meaning when `wr_en_o` is 0.
- R2: Byte mode (`byte_i`=1) applies to codes 0 to 4 and 7 to 18:
  - The operation works on bits 7:0.
  - N is taken from bit 7, and Z is set only when bits 7:0 are zero.
  - Carry and overflow are formed at bit 7.
  - `res_o[15:8]` equals `dst_i[15:8]`.
  
  For add, subtract, swap and sign extend, `byte_i` has no effect.
- R3: Move stores src. Bit clear stores ~src & dst. Bit set stores src | dst. Bit test evaluates src & dst. For all four, N and Z follow that value, V is 0 and C is unchanged.
- R4: Add stores dst + src and sets C to the carry out. Subtract stores dst - src and sets C to the borrow (dst < src, unsigned). For both, V is set on signed overflow, and N and Z follow the result.
- R5: Compare evaluates src - dst. It sets N and Z from that value, C from the borrow (src < dst, unsigned) and V from signed overflow.
- R6: Increment and decrement add or subtract one and leave C unchanged. V is set when increment starts from the largest positive value, or when decrement starts from the most negative value.
- R7: Negate stores the two's complement of dst. C is set when the result is non-zero, and V is set when the result is the most negative value.
- R8: Add carry stores dst + C, and subtract carry stores dst - C. In both, C reports the carry out or borrow of that step, and V reports signed overflow.
- R9: Clear stores zero and gives N=0, Z=1, V=0, C=0. Complement stores ~dst and gives V=0, C=1. Test sets N and Z from dst and clears V and C.
- R10: Rotate right shifts the old C into the top bit and bit 0 into C. Rotate left shifts the old C into bit 0 and the top bit into C. V equals N XOR C, both taken after the operation.
- R11: Arithmetic shift right keeps the top bit and puts bit 0 into C. Arithmetic shift left fills bit 0 with zero and puts the top bit into C. V equals N XOR C, both taken after the operation.
- R12: Swap exchanges the two bytes of dst. N is taken from bit 7 of the result, Z is set when bits 7:0 of the result are zero, and V and C are cleared.
- R13: Sign extend stores all ones when the incoming N is 1 and all zeros when it is 0. N and C are unchanged, Z is the inverse of N, and V is 0.
- R14: Codes 21 to 31 leave `flags_o` equal to `flags_i` and drive `wr_en_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Decoded operation code (encoding in R1) |
| byte_i | input | 1 | Byte-width select |
| src_i | input | 16 | Source operand |
| dst_i | input | 16 | Destination operand |
| flags_i | input | 4 | Current flags {N,Z,V,C}, N in bit 3 and C in bit 0 |
| res_o | output | 16 | Result word |
| wr_en_o | output | 1 | Result should be written back |
| flags_o | output | 4 | Next flags {N,Z,V,C} |

## Verification
The case where byte narrowing and carry or overflow generation happen in the same evaluation carries the most risk. Correct behaviour requires three things at once: the carry and sign must be taken at bit 7, and the destination's upper byte must still pass through unchanged. To provoke this, the bench sweeps every code in both widths against operand values such as 0x007F, 0x0080, 0x00FF and 0xA5C3. These values overflow the low byte while the upper byte holds unrelated bits. A bench model works with integers masked to the active width, and it judges every vector on three outputs: the merged result word, the flags, and the write-back enable.

// File: rtl/wb_alu_pkg.sv
package wb_alu_pkg;

    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_MOV  = 5'd0,
        OP_CMP  = 5'd1,
        OP_BIT  = 5'd2,
        OP_BIC  = 5'd3,
        OP_BIS  = 5'd4,
        OP_ADD  = 5'd5,
        OP_SUB  = 5'd6,
        OP_CLR  = 5'd7,
        OP_COM  = 5'd8,
        OP_INC  = 5'd9,
        OP_DEC  = 5'd10,
        OP_NEG  = 5'd11,
        OP_ADC  = 5'd12,
        OP_SBC  = 5'd13,
        OP_TST  = 5'd14,
        OP_ROR  = 5'd15,
        OP_ROL  = 5'd16,
        OP_ASR  = 5'd17,
        OP_ASL  = 5'd18,
        OP_SWAB = 5'd19,
        OP_SXT  = 5'd20
    } op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    // Operation may be narrowed to the low byte
    function automatic logic byte_capable(op_e op);
        return (op <= OP_BIS) || ((op >= OP_CLR) && (op <= OP_ASL));
    endfunction

    // Operation only updates flags
    function automatic logic flags_only(op_e op);
        return (op == OP_CMP) || (op == OP_BIT) || (op == OP_TST);
    endfunction

endpackage

// File: rtl/wb_alu_arith.sv
module wb_alu_arith
    import wb_alu_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  op_e               op,
    input  logic              narrow,
    input  logic [WORD_W-1:0] src,
    input  logic [WORD_W-1:0] dst,
    input  logic              c_in,
    output logic [WORD_W-1:0] sum,
    output logic              cout,
    output logic              ovf
);
    localparam int HALF_W = WORD_W / 2;

    logic [WORD_W-1:0] x, y;
    logic              cin;
    logic [WORD_W:0]   full;
    logic [HALF_W:0]   low;
    logic              sx, sy, sr;

    // All adder-based operations reduce to x + y + cin
    always_comb begin
        x   = dst;
        y   = '0;
        cin = 1'b0;
        unique case (op)
            OP_ADD: y = src;
            OP_SUB: begin y = ~src; cin = 1'b1; end
            OP_CMP: begin x = src; y = ~dst; cin = 1'b1; end
            OP_INC: cin = 1'b1;
            OP_DEC: y = '1;
            OP_NEG: begin x = '0; y = ~dst; cin = 1'b1; end
            OP_ADC: cin = c_in;
            OP_SBC: begin y = '1; cin = ~c_in; end
            default: ;
        endcase
    end

    always_comb begin
        full = {1'b0, x} + {1'b0, y} + {{WORD_W{1'b0}}, cin};
        low  = {1'b0, x[HALF_W-1:0]} + {1'b0, y[HALF_W-1:0]} + {{HALF_W{1'b0}}, cin};
        sum  = full[WORD_W-1:0];
        cout = narrow ? low[HALF_W] : full[WORD_W];
        sx   = narrow ? x[HALF_W-1] : x[WORD_W-1];
        sy   = narrow ? y[HALF_W-1] : y[WORD_W-1];
        sr   = narrow ? low[HALF_W-1] : full[WORD_W-1];
        ovf  = (sx == sy) && (sr != sx);
    end

endmodule

// File: rtl/wb_alu_shift.sv
module wb_alu_shift
    import wb_alu_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  op_e               op,
    input  logic              narrow,
    input  logic [WORD_W-1:0] dst,
    input  logic              c_in,
    output logic [WORD_W-1:0] res,
    output logic              c_out
);
    localparam int HALF_W = WORD_W / 2;

    logic [HALF_W-1:0] lo;
    logic [WORD_W-1:0] wd;
    logic              top_l, top_w;

    always_comb begin
        lo    = dst[HALF_W-1:0];
        wd    = dst;
        top_l = lo[HALF_W-1];
        top_w = wd[WORD_W-1];
        res   = dst;
        c_out = c_in;
        unique case (op)
            OP_ROR: begin
                c_out = dst[0];
                res   = narrow ? {dst[WORD_W-1:HALF_W], c_in, lo[HALF_W-1:1]}
                               : {c_in, wd[WORD_W-1:1]};
            end
            OP_ROL: begin
                c_out = narrow ? top_l : top_w;
                res   = narrow ? {dst[WORD_W-1:HALF_W], lo[HALF_W-2:0], c_in}
                               : {wd[WORD_W-2:0], c_in};
            end
            OP_ASR: begin
                c_out = dst[0];
                res   = narrow ? {dst[WORD_W-1:HALF_W], top_l, lo[HALF_W-1:1]}
                               : {top_w, wd[WORD_W-1:1]};
            end
            OP_ASL: begin
                c_out = narrow ? top_l : top_w;
                res   = narrow ? {dst[WORD_W-1:HALF_W], lo[HALF_W-2:0], 1'b0}
                               : {wd[WORD_W-2:0], 1'b0};
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/wb_alu_logic.sv
module wb_alu_logic
    import wb_alu_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  op_e               op,
    input  logic [WORD_W-1:0] src,
    input  logic [WORD_W-1:0] dst,
    input  logic              n_in,
    output logic [WORD_W-1:0] res
);
    localparam int HALF_W = WORD_W / 2;

    always_comb begin
        unique case (op)
            OP_MOV:  res = src;
            OP_BIT:  res = src & dst;
            OP_BIC:  res = ~src & dst;
            OP_BIS:  res = src | dst;
            OP_CLR:  res = '0;
            OP_COM:  res = ~dst;
            OP_SWAB: res = {dst[HALF_W-1:0], dst[WORD_W-1:HALF_W]};
            OP_SXT:  res = {WORD_W{n_in}};
            default: res = dst;
        endcase
    end

endmodule

// File: rtl/wb_alu.sv
module wb_alu
    import wb_alu_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic [4:0]        op_i,
    input  logic              byte_i,
    input  logic [WORD_W-1:0] src_i,
    input  logic [WORD_W-1:0] dst_i,
    input  logic [3:0]        flags_i,
    output logic [WORD_W-1:0] res_o,
    output logic              wr_en_o,
    output logic [3:0]        flags_o
);
    localparam int HALF_W = WORD_W / 2;

    typedef enum logic [1:0] {CLS_LOGIC, CLS_ARITH, CLS_SHIFT} cls_e;

    op_e    op;
    flags_t fin, fout;
    logic   narrow, known;
    cls_e   cls;

    logic [WORD_W-1:0] ar_res, sh_res, lg_res, raw, r;
    logic              ar_cout, ar_ovf, sh_c;
    logic              ns, zs;

    assign op     = op_e'(op_i);
    assign fin    = flags_t'(flags_i);
    assign known  = (op_i <= 5'd20);
    assign narrow = byte_i && known && byte_capable(op);

    wb_alu_arith #(.WORD_W(WORD_W)) u_arith (
        .op(op), .narrow(narrow), .src(src_i), .dst(dst_i), .c_in(fin.c),
        .sum(ar_res), .cout(ar_cout), .ovf(ar_ovf)
    );

    wb_alu_shift #(.WORD_W(WORD_W)) u_shift (
        .op(op), .narrow(narrow), .dst(dst_i), .c_in(fin.c),
        .res(sh_res), .c_out(sh_c)
    );

    wb_alu_logic #(.WORD_W(WORD_W)) u_logic (
        .op(op), .src(src_i), .dst(dst_i), .n_in(fin.n), .res(lg_res)
    );

    always_comb begin
        unique case (op)
            OP_ADD, OP_SUB, OP_CMP, OP_INC, OP_DEC,
            OP_NEG, OP_ADC, OP_SBC:         cls = CLS_ARITH;
            OP_ROR, OP_ROL, OP_ASR, OP_ASL: cls = CLS_SHIFT;
            default:                        cls = CLS_LOGIC;
        endcase
        unique case (cls)
            CLS_ARITH: raw = ar_res;
            CLS_SHIFT: raw = sh_res;
            default:   raw = lg_res;
        endcase
        r  = narrow ? {dst_i[WORD_W-1:HALF_W], raw[HALF_W-1:0]} : raw;
        ns = narrow ? r[HALF_W-1] : r[WORD_W-1];
        zs = narrow ? (r[HALF_W-1:0] == '0) : (r == '0);
    end

    always_comb begin
        fout = '{n: ns, z: zs, v: 1'b0, c: fin.c};
        unique case (op)
            OP_MOV, OP_BIT, OP_BIC, OP_BIS: ;
            OP_ADD, OP_ADC:                 begin fout.v = ar_ovf; fout.c = ar_cout;  end
            OP_SUB, OP_CMP, OP_SBC:         begin fout.v = ar_ovf; fout.c = ~ar_cout; end
            OP_INC, OP_DEC:                 fout.v = ar_ovf;
            OP_NEG:                         begin fout.v = ar_ovf; fout.c = ~zs; end
            OP_CLR, OP_TST:                 fout.c = 1'b0;
            OP_COM:                         fout.c = 1'b1;
            OP_ROR, OP_ROL, OP_ASR, OP_ASL: begin fout.c = sh_c; fout.v = ns ^ sh_c; end
            OP_SWAB: fout = '{n: r[HALF_W-1], z: (r[HALF_W-1:0] == '0), v: 1'b0, c: 1'b0};
            OP_SXT:  fout = '{n: fin.n, z: ~fin.n, v: 1'b0, c: fin.c};
            default: fout = fin;
        endcase
    end

    assign res_o   = r;
    assign wr_en_o = known && !flags_only(op);
    assign flags_o = fout;

    // Checks on relations between the separately built pieces
    always_comb begin
        if (narrow) begin
            AST_UPPER_BYTE_KEPT: assert (res_o[WORD_W-1:HALF_W] == dst_i[WORD_W-1:HALF_W]) // R2
                else $error("upper byte disturbed in byte mode");
        end
        if (op_i == 5'd7) begin
            AST_CLEAR_FLAGS: assert (res_o[HALF_W-1:0] == '0 && flags_o == 4'b0100) // R9
                else $error("clear flags wrong");
        end
        if (op_i == 5'd8) begin
            AST_COMPLEMENT_CARRY: assert (flags_o[0] && !flags_o[1]) // R9
                else $error("complement flags wrong");
        end
        if (op_i >= 5'd15 && op_i <= 5'd18) begin
            AST_SHIFT_OVERFLOW: assert (flags_o[1] == (flags_o[3] ^ flags_o[0])) // R10
                else $error("shift overflow flag wrong");
        end
        if (op_i == 5'd20) begin
            AST_SIGN_EXTEND_FILL: assert ((res_o == '0) || (res_o == '1)) // R13
                else $error("sign extend not uniform");
        end
        if (op_i > 5'd20) begin
            AST_UNDEFINED_QUIET: assert (!wr_en_o && flags_o == flags_i) // R14
                else $error("undefined code had an effect");
        end
        if (op_i == 5'd1 || op_i == 5'd2 || op_i == 5'd14) begin
            AST_FLAGS_ONLY_NO_WRITE: assert (!wr_en_o) // R1
                else $error("flag-only operation requested write");
        end
    end

endmodule

// File: tb/wb_alu_test.sv
module wb_alu_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVALS      = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  op;
    logic        byt;
    logic [15:0] src, dst, res;
    logic [3:0]  fin, fout;
    logic        we;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wb_alu uut (
        .op_i(op), .byte_i(byt), .src_i(src), .dst_i(dst), .flags_i(fin),
        .res_o(res), .wr_en_o(we), .flags_o(fout)
    );

    logic [15:0] vals [NVALS];

    function automatic string tag_of(int o);
        case (o)
            0, 2, 3, 4: return "R3";
            1:          return "R5";
            5, 6:       return "R4";
            7, 8, 14:   return "R9";
            9, 10:      return "R6";
            11:         return "R7";
            12, 13:     return "R8";
            15, 16:     return "R10";
            17, 18:     return "R11";
            19:         return "R12";
            20:         return "R13";
            default:    return "R14";
        endcase
    endfunction

    // Model from the requirements: integer arithmetic masked to the active width
    task automatic model(input int o, input bit b, input int s16, input int d16,
                         input bit fn, input bit fz, input bit fv, input bit fc,
                         output int er, output bit ewe, output bit [3:0] ef);
        bit nar;
        int w_mask, msb, a, s, r;
        bit n, z, v, c;
        nar    = b && ((o <= 4) || (o >= 7 && o <= 18));
        w_mask = nar ? 'hFF : 'hFFFF;
        msb    = nar ? 'h80 : 'h8000;
        a = d16 & w_mask;
        s = s16 & w_mask;
        r = a; v = 0; c = fc;
        ewe = (o <= 20) && o != 1 && o != 2 && o != 14;
        case (o)
            0:  r = s;
            1:  begin r = (s - a) & w_mask; c = s < a;
                      v = ((s & msb) != (a & msb)) && ((r & msb) == (a & msb)); end
            2:  r = s & a;
            3:  r = ~s & a & w_mask;
            4:  r = s | a;
            5:  begin r = (a + s) & w_mask; c = (a + s) > w_mask;
                      v = ((a & msb) == (s & msb)) && ((r & msb) != (a & msb)); end
            6:  begin r = (a - s) & w_mask; c = a < s;
                      v = ((a & msb) != (s & msb)) && ((r & msb) == (s & msb)); end
            7:  begin r = 0; c = 0; end
            8:  begin r = ~a & w_mask; c = 1; end
            9:  begin r = (a + 1) & w_mask; v = (a == (w_mask >> 1)); end
            10: begin r = (a - 1) & w_mask; v = (a == msb); end
            11: begin r = (0 - a) & w_mask; c = (r != 0); v = (r == msb); end
            12: begin r = (a + fc) & w_mask; c = fc && (a == w_mask); v = fc && (a == (w_mask >> 1)); end
            13: begin r = (a - fc) & w_mask; c = fc && (a == 0); v = fc && (a == msb); end
            14: c = 0;
            15: begin r = (a >> 1) | (fc ? msb : 0); c = a[0]; end
            16: begin r = ((a << 1) & w_mask) | int'(fc); c = (a & msb) != 0; end
            17: begin r = (a >> 1) | (a & msb); c = a[0]; end
            18: begin r = (a << 1) & w_mask; c = (a & msb) != 0; end
            default: ;
        endcase
        n = (r & msb) != 0;
        z = (r == 0);
        if (o >= 15 && o <= 18) v = n ^ c;
        er = nar ? ((d16 & 'hFF00) | r) : r;
        if (o == 19) begin
            er = ((d16 & 'hFF) << 8) | ((d16 >> 8) & 'hFF);
            n = (er & 'h80) != 0; z = (er & 'hFF) == 0; v = 0; c = 0;
        end
        if (o == 20) begin
            er = fn ? 'hFFFF : 0; n = fn; z = !fn; v = 0; c = fc;
        end
        if (o > 20) begin n = fn; z = fz; v = fv; c = fc; end
        ef = {n, z, v, c};
    endtask

    task automatic check(input string rq);
        int er; bit ewe; bit [3:0] ef; bit ok;
        model(int'(op), byt, int'(src), int'(dst), fin[3], fin[2], fin[1], fin[0], er, ewe, ef);
        total++;
        ok = (we == ewe) && (fout == ef) && (!ewe || (res == er[15:0]));
        if (!ok) begin
            bad++;
            $display("FAIL %s op=%0d byte=%0b src=%h dst=%h fin=%b: res=%h exp %h we=%b exp %b flags=%b exp %b",
                     rq, op, byt, src, dst, fin, res, er[15:0], we, ewe, fout, ef);
        end
    endtask

    initial begin
        vals = '{16'h0000, 16'h0001, 16'h007F, 16'h0080, 16'h00FF, 16'h0100,
                 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234, 16'hA5C3, 16'h0F0F};
        op = 5'd0; byt = 1'b0; src = '0; dst = '0; fin = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // Idle state: move of zero gives zero, Z set, write requested (R1, R3)
        check("R1");
        // Byte input ignored for add, subtract, swap, sign extend (R2)
        foreach (vals[i]) begin
            for (int o = 5; o <= 20; o++) begin
                if (o == 5 || o == 6 || o == 19 || o == 20) begin
                    @(posedge clk);
                    op = o[4:0]; byt = 1'b1; src = vals[i]; dst = vals[NVALS-1-i]; fin = 4'b1001;
                    @(negedge clk);
                    check("R2");
                end
            end
        end
        // Full sweep: every code, both widths, operand pairs, N and C inputs
        for (int o = 0; o < 32; o++) begin
            for (int b = 0; b < 2; b++) begin
                for (int si = 0; si < NVALS; si++) begin
                    for (int di = 0; di < NVALS; di++) begin
                        for (int f = 0; f < 4; f++) begin
                            @(posedge clk);
                            op  = o[4:0];
                            byt = b[0];
                            src = vals[si];
                            dst = vals[di];
                            fin = {f[1], ~f[1], f[0], f[0]};
                            @(negedge clk);
                            check(b == 1 ? (o <= 18 ? "R2" : tag_of(o)) : tag_of(o));
                        end
                    end
                end
            end
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule